// File: doc/BRIEF.md
# FEAC Codeword Transmit Sequencer

This block drives the outgoing serial far-end alarm and control bit stream of a DS3 framer. Software loads two 6-bit alarm codes, A and B, and picks one of four modes: idle, single, dual or continuous. A single or dual burst begins with a start strobe. Continuous mode needs no strobe. Each code is framed into a 16-bit codeword and shifted out one bit for each cycle in which the line-side enable is high. When no codeword is due, the stream is all ones.

Every decision is taken on a 16-bit slot boundary. These decisions are starting a burst, moving from code A to code B, ending a burst and reacting to a mode change. So the line never carries a partial codeword. A done flag goes high when a single or dual burst has sent all of its codewords. It stays high until the next burst starts.

Top module: `feac_tx_seq`

## Requirements
- R1: A write with `wr_en`=1 and `wr_sel`=0 loads code A, and with `wr_sel`=1 it loads code B. Register bit 0 holds the first-sent code bit C1 and bit 5 holds the last-sent bit C6. A new code value is first used at the next codeword boundary.
- R2: A codeword is 16 serial bits sent in this order: 0, then C1 to C6 (register bits 0 to 5), then 0, then eight 1s.
- R3: The stream moves forward one bit in each cycle where `line_en` is 1. When `line_en` is 0, the position in the stream and `tx_bit` stay unchanged.
- R4: When no codeword is being sent, `tx_bit` is 1. Idle mode (`mode`=0) sends only ones.
- R5: In single mode (`mode`=1), a start strobe causes code A's codeword to be sent exactly 10 times in a row. The stream then returns to ones and `burst_done` is set.
- R6: In dual mode (`mode`=2), a start strobe causes code A's codeword to be sent 10 times and then code B's codeword 10 times. The stream then returns to ones and `burst_done` is set.
- R7: In continuous mode (`mode`=3), code A's codeword repeats back to back for as long as that mode is selected. This happens without a start strobe.
- R8: A start strobe is held as pending and acts at the next 16-bit boundary. A mode change also acts only at a boundary. Idle or continuous mode selected during a burst ends that burst without setting `burst_done`.
- R9: `burst_done` clears at the boundary where the next burst starts.
- R10: After reset, `tx_bit` is 1, `burst_done` is 0, both codes are 0, the mode sequencing is idle and the stream position is at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_en | input | 1 | Line-side bit enable, one serial bit per high cycle |
| wr_en | input | 1 | Code register write strobe |
| wr_sel | input | 1 | Code register select: 0 = A, 1 = B |
| wr_data | input | 6 | Code value, bit 0 = C1 |
| mode | input | 2 | 0 idle, 1 single, 2 dual, 3 continuous |
| start | input | 1 | Burst start strobe for single and dual modes |
| tx_bit | output | 1 | Serial FEAC output bit |
| burst_done | output | 1 | Burst finished flag |

## Verification
A wrong repeat count or a wrong A-to-B handover shows on `tx_bit` within one codeword. The first extra or missing frame puts a 0 where a 1 is due, or the reverse, and `burst_done` rises 16 enables early or late. If the stream position slips during enable-low cycles, the framing zeros move, and this shows within 16 enables. A reversed code bit order shows in the first codeword. A slot change off a boundary breaks the zero-then-code-then-zero pattern at once.

// File: rtl/feac_pkg.sv
package feac_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_A    = 2'd1,
    SLOT_B    = 2'd2
  } slot_e;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DUAL   = 2'd2,
    MODE_CONT   = 2'd3
  } mode_e;
endpackage

// File: rtl/feac_code_regs.sv
module feac_code_regs #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b
);
  logic [CODE_W-1:0] store_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    logic              ld;
    logic [CODE_W-1:0] nxt;
    always_comb begin
      ld  = wr_en && (wr_sel == 1'(g));
      nxt = ld ? wr_data : store_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) store_q[g] <= '0;
      else        store_q[g] <= nxt;
    end
  end

  assign code_a = store_q[0];
  assign code_b = store_q[1];
endmodule

// File: rtl/feac_serializer.sv
module feac_serializer
  import feac_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int FLAG_ONES = 8,
  localparam int FRAME_W  = CODE_W + 2 + FLAG_ONES,
  localparam int IDX_W    = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_en,
  input  slot_e             kind,
  input  logic [CODE_W-1:0] code,
  output logic [IDX_W-1:0]  idx,
  output logic              wrap,
  output logic              tx_bit
);
  logic [FRAME_W-1:0] frame;
  logic [IDX_W-1:0]   idx_q, idx_d;

  always_comb begin
    frame[0]        = 1'b0;
    frame[CODE_W+1] = 1'b0;
  end
  for (genvar i = 0; i < CODE_W; i++) begin : g_code
    assign frame[1+i] = code[i];
  end
  for (genvar j = 0; j < FLAG_ONES; j++) begin : g_flag
    assign frame[CODE_W+2+j] = 1'b1;
  end

  always_comb begin
    wrap  = line_en && (idx_q == IDX_W'(FRAME_W-1));
    idx_d = idx_q;
    if (line_en) idx_d = wrap ? '0 : idx_q + 1'b1;
    tx_bit = (kind == SLOT_IDLE) ? 1'b1 : frame[idx_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx = idx_q;
endmodule

// File: rtl/feac_sequencer.sv
module feac_sequencer
  import feac_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int REPEATS = 10,
  localparam int REP_W  = $clog2(REPEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [1:0]        mode,
  input  logic              start,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  output slot_e             kind,
  output logic [CODE_W-1:0] cur_code,
  output logic              burst_done
);
  slot_e             kind_q, kind_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              busy_q, busy_d, dual_q, dual_d;
  logic              pend_q, pend_d, done_q, done_d;
  logic              take;

  always_comb begin
    kind_d = kind_q;
    rep_d  = rep_q;
    code_d = code_q;
    busy_d = busy_q;
    dual_d = dual_q;
    done_d = done_q;
    take   = 1'b0;
    if (wrap) begin
      if (mode == MODE_IDLE) begin
        kind_d = SLOT_IDLE;
        busy_d = 1'b0;
      end else if (mode == MODE_CONT) begin
        kind_d = SLOT_A;
        code_d = code_a;
        busy_d = 1'b0;
      end else if (pend_q) begin
        take   = 1'b1;
        kind_d = SLOT_A;
        code_d = code_a;
        rep_d  = '0;
        busy_d = 1'b1;
        dual_d = (mode == MODE_DUAL);
        done_d = 1'b0;
      end else if (busy_q) begin
        if (rep_q == REP_W'(REPEATS-1)) begin
          rep_d = '0;
          if (kind_q == SLOT_A && dual_q) begin
            kind_d = SLOT_B;
            code_d = code_b;
          end else begin
            kind_d = SLOT_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
          end
        end else begin
          rep_d  = rep_q + 1'b1;
          code_d = (kind_q == SLOT_B) ? code_b : code_a;
        end
      end else begin
        kind_d = SLOT_IDLE;
      end
    end
    pend_d = start || (pend_q && !take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= SLOT_IDLE;
      rep_q  <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
      dual_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      rep_q  <= rep_d;
      code_q <= code_d;
      busy_q <= busy_d;
      dual_q <= dual_d;
      pend_q <= pend_d;
      done_q <= done_d;
    end
  end

  assign kind       = kind_q;
  assign cur_code   = code_q;
  assign burst_done = done_q;
endmodule

// File: rtl/feac_tx_seq.sv
module feac_tx_seq
  import feac_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int REPEATS   = 10,
  parameter int FLAG_ONES = 8,
  localparam int FRAME_W  = CODE_W + 2 + FLAG_ONES,
  localparam int IDX_W    = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_en,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              start,
  output logic              tx_bit,
  output logic              burst_done
);
  logic [CODE_W-1:0] code_a, code_b, cur_code;
  slot_e             slot_kind;
  logic [IDX_W-1:0]  bit_idx;
  logic              slot_wrap;

  feac_code_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .code_a(code_a), .code_b(code_b)
  );

  feac_sequencer #(.CODE_W(CODE_W), .REPEATS(REPEATS)) u_seq (
    .clk(clk), .rst_n(rst_n), .wrap(slot_wrap), .mode(mode), .start(start),
    .code_a(code_a), .code_b(code_b), .kind(slot_kind),
    .cur_code(cur_code), .burst_done(burst_done)
  );

  feac_serializer #(.CODE_W(CODE_W), .FLAG_ONES(FLAG_ONES)) u_ser (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .kind(slot_kind),
    .code(cur_code), .idx(bit_idx), .wrap(slot_wrap), .tx_bit(tx_bit)
  );
endmodule

// File: rtl/feac_tx_seq_chk.sv
module feac_tx_seq_chk
  import feac_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int IDX_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_en,
  input logic             tx_bit,
  input logic             burst_done,
  input slot_e            kind,
  input logic [IDX_W-1:0] idx,
  input logic             wrap
);
  // R4
  idle_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == SLOT_IDLE) |-> tx_bit);
  // R2
  lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != SLOT_IDLE && idx == '0) |-> !tx_bit);
  // R2
  flag_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= IDX_W'(CODE_W+2)) |-> tx_bit);
  // R3
  hold_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |=> $stable(idx));
  // R8
  slot_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(kind));
  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_done) |-> $past(wrap));
endmodule

bind feac_tx_seq feac_tx_seq_chk #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_en(line_en), .tx_bit(tx_bit),
  .burst_done(burst_done), .kind(slot_kind), .idx(bit_idx), .wrap(slot_wrap)
);

// File: tb/feac_tx_seq_test.sv
module feac_tx_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, start = 1'b0;
  logic [5:0] wr_data = '0;
  logic [1:0] mode = 2'd0;
  logic       tx_bit, burst_done;

  feac_tx_seq uut (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .mode(mode), .start(start),
    .tx_bit(tx_bit), .burst_done(burst_done)
  );

  always #4 clk = ~clk;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  string req = "R10";

  // behavioural reference
  int   m_pos = 0, m_cur = 0;     // m_cur: 0 none, 1 A, 2 B
  bit   [5:0] m_ca = 0, m_cb = 0, m_code = 0;
  bit   m_done = 0, m_pend = 0, m_burst = 0;
  int   m_q[$];

  function automatic bit m_bit();
    if (m_cur == 0) return 1'b1;
    if (m_pos == 0 || m_pos == 7) return 1'b0;
    if (m_pos >= 8) return 1'b1;
    return m_code[m_pos-1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_cur = 0; m_ca = 0; m_cb = 0; m_code = 0;
      m_done = 0; m_pend = 0; m_burst = 0; m_q.delete();
    end else begin
      if (line_en) begin
        if (m_pos == 15) begin
          m_pos = 0;
          if (mode == 0) begin
            m_q.delete(); m_burst = 0; m_cur = 0;
          end else if (mode == 3) begin
            m_q.delete(); m_burst = 0; m_cur = 1;
          end else if (m_pend) begin
            m_pend = 0; m_done = 0; m_burst = 1; m_q.delete();
            for (int k = 0; k < 9; k++) m_q.push_back(1);
            if (mode == 2) for (int k = 0; k < 10; k++) m_q.push_back(2);
            m_cur = 1;
          end else if (m_burst) begin
            if (m_q.size() == 0) begin
              m_burst = 0; m_done = 1; m_cur = 0;
            end else m_cur = m_q.pop_front();
          end else m_cur = 0;
          if (m_cur == 1) m_code = m_ca;
          if (m_cur == 2) m_code = m_cb;
        end else m_pos++;
      end
      if (start) m_pend = 1;
      if (wr_en) begin
        if (wr_sel) m_cb = wr_data; else m_ca = wr_data;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      n_checks++;
      if (tx_bit !== m_bit()) begin
        n_fail++;
        $display("FAIL %s tx_bit actual %b expected %b at cycle %0d", req, tx_bit, m_bit(), cycles);
      end
      n_checks++;
      if (burst_done !== m_done) begin
        n_fail++;
        $display("FAIL %s burst_done actual %b expected %b at cycle %0d", req, burst_done, m_done, cycles);
      end
    end
    if (cycles > 60000) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected <= 60000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // gap: 0 = enable always, else enable low every gap-th cycle
  task automatic run(int n, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_en = (gap == 0) ? 1'b1 : ((i % gap) != 0);
      start = 1'b0; wr_en = 1'b0;
    end
  endtask

  task automatic write_code(bit sel, bit [5:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R10"; run(5, 0);
    line_en = 1'b0;
    req = "R1"; write_code(0, 6'b101101); write_code(1, 6'b010011);
    req = "R4"; run(40, 0);
    req = "R5"; mode = 2'd1; pulse_start(); run(220, 0);
    req = "R6"; mode = 2'd2; pulse_start(); run(560, 3);
    req = "R3"; run(60, 2);
    req = "R9"; mode = 2'd1; pulse_start(); run(50, 0);
    req = "R8"; write_code(0, 6'b110001); run(60, 0);
    mode = 2'd0; run(5, 0);
    req = "R8"; run(40, 0);
    req = "R2"; mode = 2'd2; pulse_start(); run(9, 0); pulse_start(); run(120, 4);
    req = "R7"; mode = 2'd3; run(140, 0);
    write_code(0, 6'b000001); run(50, 5);
    req = "R8"; mode = 2'd0; run(50, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule